// File: doc/BRIEF.md
# Priority Reference Selector with Pair Interlock

This block keeps a 4-bit priority for each of six candidate reference clocks and names, each cycle, the best candidate that is usable. A candidate is usable when its priority is nonzero and its availability flag is high. Value 1 is the most preferred and 15 the least. Equal values are allowed, and the lower input number wins a tie. A control input can suppress automatic selection entirely.

Priorities are loaded through a simple write port that carries an index and a value. Two pairs of inputs (2 with 4, and 3 with 5, numbered from 0) may not both be enabled. Writing a nonzero value to one member of a pair clears the other member in the same clock edge. All six priorities can be read back at any time on one flat bus. The selection output is registered, so it follows its inputs by one clock.

Top module: `ref_sel_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first write, the priority fields hold input0=1, input1=2, input2=3, input3=4, input4=0, input5=0, and `sel_valid`=0, `sel_idx`=0. Field k of `prio_rd` is bits [4k+3:4k].
- R2: When `wr_en` is high at a rising edge and `wr_idx` is 0 to 5, field `wr_idx` takes `wr_prio` after that edge. If `wr_idx` is 6 or 7, no field changes.
- R3: A nonzero write to input 2 sets the priority of input 4 to 0 on the same edge, and a nonzero write to input 4 does the same to input 2. Fields 2 and 4 are never both nonzero.
- R4: A nonzero write to input 3 sets the priority of input 5 to 0 on the same edge, and a nonzero write to input 5 does the same to input 3. Fields 3 and 5 are never both nonzero.
- R5: A write of 0 to any member of a pair leaves its partner's priority unchanged.
- R6: At each rising edge with `sel_off`=0, the usable input with the numerically smallest priority is loaded into `sel_idx`, and `sel_valid` goes high. An input is usable when its field is nonzero and its bit in `avail` is 1.
- R7: When two or more usable inputs share the smallest priority value, the lowest-numbered one is selected.
- R8: At a rising edge with `sel_off`=1, `sel_valid` goes to 0 and `sel_idx` keeps its previous value, whatever the priorities and `avail` are.
- R9: At a rising edge with `sel_off`=0 and no usable input, `sel_valid` goes to 0 and `sel_idx` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Priority write strobe |
| wr_idx | input | 3 | Input number to write (0 to 5 are valid) |
| wr_prio | input | 4 | Priority value to write (0 disables the input) |
| avail | input | 6 | Per-input availability flag, bit k for input k |
| sel_off | input | 1 | 1 suppresses automatic selection |
| sel_idx | output | 3 | Selected input number |
| sel_valid | output | 1 | High when sel_idx names a usable input |
| prio_rd | output | 24 | Read-back of all six priority fields |

## Verification
Selection is swept over all 64 availability patterns for each of several priority sets. The sets have distinct values, full ties, partial ties at different ranks, and disabled inputs, so the sweep can tell a faulty comparison, a wrong tie rule and a missed disable apart. Interlock writes are made in both directions on both pairs, each with nonzero and zero values, and read back at once. This shows whether the clear goes to the correct partner and fires only on nonzero writes. Runs with selection suppressed and with no usable input then show that the last index is held.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

  localparam int NUM_REF   = 6;
  localparam int PRIO_W    = 4;
  localparam int PAIR_BASE = 2;  // first input that belongs to a pair
  localparam int PAIR_GAP  = 2;  // distance between partners

  // Partner of input i under the interlock, or -1 when i is unpaired.
  function automatic int partner_of(input int i);
    if (i >= PAIR_BASE && i < PAIR_BASE + PAIR_GAP)
      return i + PAIR_GAP;
    if (i >= PAIR_BASE + PAIR_GAP && i < PAIR_BASE + 2 * PAIR_GAP)
      return i - PAIR_GAP;
    return -1;
  endfunction

  // Reset priority: upper members of pairs start disabled, others rank by number.
  function automatic int default_prio(input int i);
    if (partner_of(i) >= 0 && i >= PAIR_BASE + PAIR_GAP)
      return 0;
    return i + 1;
  endfunction

  // True when priority a is strictly preferred over b (smaller wins).
  function automatic logic prio_beats(input logic [PRIO_W-1:0] a,
                                      input logic [PRIO_W-1:0] b);
    return a < b;
  endfunction

endpackage

// File: rtl/ref_prio_regs.sv
module ref_prio_regs #(
  parameter int NUM_REF = ref_sel_pkg::NUM_REF,
  parameter int PRIO_W  = ref_sel_pkg::PRIO_W,
  localparam int IDX_W  = $clog2(NUM_REF)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [PRIO_W-1:0]               wr_prio,
  output logic [NUM_REF-1:0][PRIO_W-1:0]  prio_q,
  output logic [NUM_REF-1:0]              pair_clr
);

  logic [NUM_REF-1:0] wr_hit;
  logic               wr_nonzero;

  assign wr_nonzero = (wr_prio != '0);

  for (genvar i = 0; i < NUM_REF; i++) begin : g_field
    localparam int PI = ref_sel_pkg::partner_of(i);
    localparam logic [PRIO_W-1:0] DEF = PRIO_W'(ref_sel_pkg::default_prio(i));

    assign wr_hit[i] = wr_en && (wr_idx == IDX_W'(i));

    if (PI >= 0) begin : g_paired
      assign pair_clr[i] = wr_en && wr_nonzero && (wr_idx == IDX_W'(PI));
    end else begin : g_single
      assign pair_clr[i] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        prio_q[i] <= DEF;
      else if (wr_hit[i])
        prio_q[i] <= wr_prio;
      else if (pair_clr[i])
        prio_q[i] <= '0;
    end
  end

endmodule

// File: rtl/ref_pick.sv
module ref_pick #(
  parameter int NUM_REF = ref_sel_pkg::NUM_REF,
  parameter int PRIO_W  = ref_sel_pkg::PRIO_W,
  localparam int IDX_W  = $clog2(NUM_REF)
) (
  input  logic [NUM_REF-1:0][PRIO_W-1:0] prio,
  input  logic [NUM_REF-1:0]             elig,
  output logic                           pick_valid,
  output logic [IDX_W-1:0]               pick_idx
);

  // Linear chain, ascending input number; strict compare keeps the lower index on ties.
  logic [NUM_REF:0]             found;
  logic [NUM_REF:0][PRIO_W-1:0] best_p;
  logic [NUM_REF:0][IDX_W-1:0]  best_i;

  assign found[0]  = 1'b0;
  assign best_p[0] = '0;
  assign best_i[0] = '0;

  for (genvar i = 0; i < NUM_REF; i++) begin : g_stage
    logic take;
    assign take = elig[i] &&
                  (!found[i] || ref_sel_pkg::prio_beats(prio[i], best_p[i]));
    assign found[i+1]  = found[i] | elig[i];
    assign best_p[i+1] = take ? prio[i]      : best_p[i];
    assign best_i[i+1] = take ? IDX_W'(i)    : best_i[i];
  end

  assign pick_valid = found[NUM_REF];
  assign pick_idx   = best_i[NUM_REF];

endmodule

// File: rtl/ref_sel_top.sv
module ref_sel_top #(
  parameter int NUM_REF = ref_sel_pkg::NUM_REF,
  parameter int PRIO_W  = ref_sel_pkg::PRIO_W,
  localparam int IDX_W  = $clog2(NUM_REF)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [PRIO_W-1:0]           wr_prio,
  input  logic [NUM_REF-1:0]          avail,
  input  logic                        sel_off,
  output logic [IDX_W-1:0]            sel_idx,
  output logic                        sel_valid,
  output logic [NUM_REF*PRIO_W-1:0]   prio_rd
);

  logic [NUM_REF-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_REF-1:0]             pair_clr;
  logic [NUM_REF-1:0]             elig;
  logic                           pick_valid;
  logic [IDX_W-1:0]               pick_idx;

  ref_prio_regs #(.NUM_REF(NUM_REF), .PRIO_W(PRIO_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_prio  (wr_prio),
    .prio_q   (prio_q),
    .pair_clr (pair_clr)
  );

  for (genvar i = 0; i < NUM_REF; i++) begin : g_elig
    assign elig[i] = avail[i] && (prio_q[i] != '0);
  end

  ref_pick #(.NUM_REF(NUM_REF), .PRIO_W(PRIO_W)) u_pick (
    .prio       (prio_q),
    .elig       (elig),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx   <= '0;
      sel_valid <= 1'b0;
    end else if (sel_off || !pick_valid) begin
      sel_valid <= 1'b0;
    end else begin
      sel_idx   <= pick_idx;
      sel_valid <= 1'b1;
    end
  end

  assign prio_rd = prio_q;

endmodule

// File: rtl/ref_sel_chk.sv
module ref_sel_chk #(
  parameter int NUM_REF = ref_sel_pkg::NUM_REF,
  parameter int PRIO_W  = ref_sel_pkg::PRIO_W,
  localparam int IDX_W  = $clog2(NUM_REF)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [IDX_W-1:0]          wr_idx,
  input logic [PRIO_W-1:0]         wr_prio,
  input logic [NUM_REF-1:0]        avail,
  input logic                      sel_off,
  input logic [IDX_W-1:0]          sel_idx,
  input logic                      sel_valid,
  input logic [NUM_REF*PRIO_W-1:0] prio_rd,
  input logic [NUM_REF-1:0]        pair_clr
);
  localparam int A0 = ref_sel_pkg::PAIR_BASE;
  localparam int B0 = A0 + ref_sel_pkg::PAIR_GAP;
  localparam int A1 = A0 + 1;
  localparam int B1 = B0 + 1;

  logic [NUM_REF-1:0]        avail_d;
  logic [NUM_REF*PRIO_W-1:0] prio_d;
  always_ff @(posedge clk) begin
    avail_d <= avail;
    prio_d  <= prio_rd;
  end

  assert_pair0_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !((prio_rd[A0*PRIO_W +: PRIO_W] != '0) && (prio_rd[B0*PRIO_W +: PRIO_W] != '0)));

  assert_pair0_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(A0) && wr_prio != '0) |=> (prio_rd[B0*PRIO_W +: PRIO_W] == '0));

  assert_pair1_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !((prio_rd[A1*PRIO_W +: PRIO_W] != '0) && (prio_rd[B1*PRIO_W +: PRIO_W] != '0)));

  assert_clear_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pair_clr));

  assert_zero_write_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(B1) && wr_prio == '0) |=> $stable(prio_rd[A1*PRIO_W +: PRIO_W]));

  assert_sel_usable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (avail_d[sel_idx] && (prio_d[sel_idx*PRIO_W +: PRIO_W] != '0)));

  assert_off_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_off) |-> !sel_valid);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> $stable(sel_idx));

endmodule

bind ref_sel_top ref_sel_chk #(.NUM_REF(NUM_REF), .PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_prio   (wr_prio),
  .avail     (avail),
  .sel_off   (sel_off),
  .sel_idx   (sel_idx),
  .sel_valid (sel_valid),
  .prio_rd   (prio_rd),
  .pair_clr  (pair_clr)
);

// File: tb/ref_sel_top_bench.sv
`timescale 1ns/1ps
module ref_sel_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [3:0]  wr_prio;
  logic [5:0]  avail;
  logic        sel_off;
  logic [2:0]  sel_idx;
  logic        sel_valid;
  logic [23:0] prio_rd;

  int vectors = 0;
  int fails   = 0;
  int model [6];
  int last_idx = 0;

  always #2.5 clk = ~clk;

  ref_sel_top u_ref_sel_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_prio(wr_prio),
    .avail(avail), .sel_off(sel_off), .sel_idx(sel_idx), .sel_valid(sel_valid),
    .prio_rd(prio_rd)
  );

  function automatic int mate(input int i);
    case (i)
      2: return 4;  4: return 2;
      3: return 5;  5: return 3;
      default: return -1;
    endcase
  endfunction

  // Scan priority levels from best to worst, inputs low to high.
  function automatic int expect_pick(input logic [5:0] av);
    for (int p = 1; p <= 15; p++)
      for (int i = 0; i < 6; i++)
        if (av[i] && model[i] == p) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_fields(input string tag);
    for (int i = 0; i < 6; i++)
      check(int'(prio_rd[4*i +: 4]) == model[i], tag, int'(prio_rd[4*i +: 4]), model[i]);
  endtask

  task automatic wr(input int idx, input int val);
    sel_off = 1'b1;
    wr_en = 1'b1; wr_idx = 3'(idx); wr_prio = 4'(val);
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (idx < 6) begin
      model[idx] = val;
      if (val != 0 && mate(idx) >= 0) model[mate(idx)] = 0;
    end
  endtask

  task automatic apply(input logic [5:0] av, input bit off, input string tag);
    int e;
    avail = av; sel_off = off;
    @(posedge clk); #1;
    e = off ? -1 : expect_pick(av);
    if (e >= 0) begin
      check(sel_valid === 1'b1, tag, int'(sel_valid), 1);
      check(int'(sel_idx) == e, tag, int'(sel_idx), e);
      last_idx = e;
    end else begin
      check(sel_valid === 1'b0, tag, int'(sel_valid), 0);
      check(int'(sel_idx) == last_idx, tag, int'(sel_idx), last_idx);
    end
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 64; a++) apply(6'(a), 1'b0, tag);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_prio = '0; avail = '0; sel_off = 1'b0;
    model = '{1, 2, 3, 4, 0, 0};
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_fields("R1 reset fields");
    check(sel_valid === 1'b0, "R1 reset valid", int'(sel_valid), 0);
    check(sel_idx == 3'd0, "R1 reset idx", int'(sel_idx), 0);
    rst_n = 1'b1;

    // R6 R9: defaults, all availability patterns
    sweep("R6 defaults");

    // R2: plain writes and ignored indices
    wr(0, 7); wr(1, 7); check_fields("R2 write");
    wr(6, 9); wr(7, 1); check_fields("R2 index 6/7 ignored");

    // R3: pair 2/4 in both directions
    wr(4, 5); check_fields("R3 write 4 clears 2");
    wr(2, 6); check_fields("R3 write 2 clears 4");
    // R4: pair 3/5 in both directions
    wr(5, 9); check_fields("R4 write 5 clears 3");
    wr(3, 2); check_fields("R4 write 3 clears 5");
    // R5: zero writes leave partner
    wr(4, 0); check_fields("R5 zero to 4 keeps 2");
    wr(5, 0); check_fields("R5 zero to 5 keeps 3");
    wr(5, 8); wr(3, 0); check_fields("R5 zero to 3 keeps 5");

    // R7: full tie
    wr(0, 3); wr(1, 3); wr(2, 3); wr(3, 3); wr(4, 0); wr(5, 0);
    check_fields("R7 tie setup");
    sweep("R7 full tie");

    // R7 R6: partial ties on two ranks, plus paired inputs enabled on the upper member
    wr(0, 9); wr(1, 4); wr(4, 4); wr(5, 9); wr(2, 0); wr(3, 0);
    check_fields("R7 partial setup");
    sweep("R7 partial tie");

    // R6: distinct, reversed order with extremes 1 and 15
    wr(0, 15); wr(1, 12); wr(2, 6); wr(5, 1); wr(3, 0); wr(4, 0);
    check_fields("R6 reversed setup");
    sweep("R6 reversed");

    // R8: suppression holds the index regardless of inputs
    apply(6'h3f, 1'b0, "R8 pre");
    for (int a = 0; a < 64; a += 7) apply(6'(a), 1'b1, "R8 suppressed");
    apply(6'h3f, 1'b0, "R8 resume");

    // R9: nothing usable holds the index
    apply(6'h04, 1'b0, "R9 pre");
    apply(6'h18, 1'b0, "R9 none usable");
    apply(6'h00, 1'b0, "R9 none available");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule